// File: doc/BRIEF.md
# Service-Toggle Watchdog with Reset Coupling

This block supervises a processor that must keep toggling one service line. After the block is released from hold, a grace window is timed. Its length is chosen by a 3-bit code, and a zero code skips the window. The first service edge ends the grace window, and from then on a normal period, chosen by a 4-bit code, is timed and restarted by every edge. If the window that is running expires with no edge, the active-low fault output `wdo_n` goes low.

The block can also be set to request a reset. In that case an expiry starts an internal reset pulse of a fixed number of milliseconds and sets a sticky cause flag. The pulse puts the watchdog back into hold, so the fault output is low for only one clock. All periods are counted in ticks of a 1 ms strobe.

Top module: `wdog_supervisor`

## Requirements
- R1: After `rst_n` is released, `wdo_n` is 1, `rst_req_o` is 0 and `cause_flag` is 0.
- R2: The normal period in ms for `cfg_tmo` codes 1..15 is 1, 2, 4, 8, 14, 27, 50, 100, 200, 400, 750, 1400, 2700, 5000, 10000. With no service, `wdo_n` falls exactly that many ticks after the last restart.
- R3: `cfg_tmo` = 0 disables the watchdog: `wdo_n` never falls and `rst_req_o` never rises.
- R4: A rising edge and a falling edge on `svc_i` each restart the count. The restart lands 3 clocks after the input changes (two sync stages plus one register).
- R5: A nonzero `cfg_start` code selects a grace period of 30, 40, 80, 120, 160, 220 or 300 s for codes 1..7. The first service edge ends the grace period and starts the normal period.
- R6: `cfg_start` = 0 means no grace period: the normal period is timed from release.
- R7: Once low, `wdo_n` stays low until a service edge restarts the count or the block is held.
- R8: While `enable` is 0, the count is held at zero and `wdo_n` is 1. Counting resumes on the clock after `enable` rises.
- R9: While `ext_rst_i` is 1, the count is held at zero and `wdo_n` returns to 1 on the next clock.
- R10: With `cfg_rst_en` = 1, an expiry raises `rst_req_o` for exactly RST_MS ticks (default 200), and `wdo_n` is low for one clock only.
- R11: With `cfg_rst_en` = 0, an expiry never raises `rst_req_o`.
- R12: `cause_flag` is set by a reset caused by the watchdog. It survives `ext_rst_i` and is cleared only by `flag_clr`.
- R13: A change of `cfg_tmo` takes effect at the next restart of the count, not during the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-clock strobe every millisecond |
| enable | input | 1 | Watchdog enable; 0 holds the count |
| ext_rst_i | input | 1 | System reset asserted from outside, active high |
| svc_i | input | 1 | Asynchronous service toggle from the processor |
| cfg_tmo | input | 4 | Normal period code, 0 disables |
| cfg_start | input | 3 | Grace period code, 0 skips it |
| cfg_rst_en | input | 1 | 1 lets an expiry request a reset |
| flag_clr | input | 1 | Clears the sticky cause flag |
| wdo_n | output | 1 | Watchdog fault, active low |
| rst_req_o | output | 1 | Reset request pulse, active high |
| cause_flag | output | 1 | Sticky: last reset came from the watchdog |

## Verification
With the tick tied high, a toggle on `svc_i` restarts the count 3 clocks later, and `wdo_n` falls L clocks after that restart. A release from hold counts as a restart in the clock it happens. On an expiry with reset coupling, `rst_req_o` and `cause_flag` rise in the same clock as the fault, `wdo_n` recovers one clock later, and `rst_req_o` falls RST_MS clocks after it rose. The bench derives each expected cycle from these latencies and queues it, and the monitor compares the outputs only in that exact cycle, checking both the cycle before an edge and the cycle of the edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef logic [3:0] tmo_code_t;
  typedef logic [2:0] start_code_t;

  // normal period in ms; code 0 means the watchdog is off
  function automatic int unsigned tmo_ms(input tmo_code_t code);
    case (code)
      4'd1:    return 1;
      4'd2:    return 2;
      4'd3:    return 4;
      4'd4:    return 8;
      4'd5:    return 14;
      4'd6:    return 27;
      4'd7:    return 50;
      4'd8:    return 100;
      4'd9:    return 200;
      4'd10:   return 400;
      4'd11:   return 750;
      4'd12:   return 1400;
      4'd13:   return 2700;
      4'd14:   return 5000;
      4'd15:   return 10000;
      default: return 0;
    endcase
  endfunction

  // grace period in ms; code 0 means no grace window
  function automatic int unsigned start_ms(input start_code_t code);
    case (code)
      3'd1:    return 30000;
      3'd2:    return 40000;
      3'd3:    return 80000;
      3'd4:    return 120000;
      3'd5:    return 160000;
      3'd6:    return 220000;
      3'd7:    return 300000;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/wdog_sync_edge.sv
module wdog_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        hold,
  input  logic        svc_edge,
  input  tmo_code_t   cfg_tmo,
  input  start_code_t cfg_start,
  output logic        fault_o,
  output logic        expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nxt;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] norm_lim, grace_lim;
  logic             fault_q, fault_d;
  logic             cnt_en;

  assign norm_lim  = CNT_W'(tmo_ms(cfg_tmo));
  assign grace_lim = CNT_W'(start_ms(cfg_start));
  assign cnt_nxt   = cnt_q + 1'b1;
  // a zero limit (watchdog off) never counts; a fault freezes the count
  assign cnt_en    = !hold && !svc_edge && tick && !fault_q && (lim_q != '0);
  assign expire_o  = cnt_en && (cnt_nxt >= lim_q);

  always_comb begin
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    fault_d = fault_q;
    if (hold) begin
      cnt_d   = '0;
      fault_d = 1'b0;
      if (norm_lim == '0)       lim_d = '0;
      else if (grace_lim == '0) lim_d = norm_lim;
      else                      lim_d = grace_lim;
    end else if (svc_edge) begin
      cnt_d   = '0;
      fault_d = 1'b0;
      lim_d   = norm_lim;
    end else if (cnt_en) begin
      cnt_d = cnt_nxt;
      if (expire_o) fault_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int RST_MS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire,
  input  logic rst_en,
  input  logic flag_clr,
  output logic rst_o,
  output logic cause_o
);
  localparam int RC_W = $clog2(RST_MS + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_MS - 1);

  logic [RC_W-1:0] rc_q, rc_d;
  logic            act_q, act_d;
  logic            cause_q, cause_d;
  logic            fire;

  assign fire = expire && rst_en && !act_q;

  always_comb begin
    act_d   = act_q;
    rc_d    = rc_q;
    cause_d = cause_q;
    if (fire) begin
      act_d = 1'b1;
      rc_d  = '0;
    end else if (act_q && tick) begin
      if (rc_q == RC_LAST) act_d = 1'b0;
      else                 rc_d  = rc_q + 1'b1;
    end
    if (fire)          cause_d = 1'b1;
    else if (flag_clr) cause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rc_q    <= '0;
      cause_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      rc_q    <= rc_d;
      cause_q <= cause_d;
    end
  end

  assign rst_o   = act_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 19,
  parameter int RST_MS      = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       enable,
  input  logic       ext_rst_i,
  input  logic       svc_i,
  input  logic [3:0] cfg_tmo,
  input  logic [2:0] cfg_start,
  input  logic       cfg_rst_en,
  input  logic       flag_clr,
  output logic       wdo_n,
  output logic       rst_req_o,
  output logic       cause_flag
);
  logic svc_edge;
  logic hold;
  logic fault;
  logic expire;

  assign hold = !enable || ext_rst_i || rst_req_o;

  wdog_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (svc_i),
    .edge_o (svc_edge)
  );

  wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_ms),
    .hold      (hold),
    .svc_edge  (svc_edge),
    .cfg_tmo   (tmo_code_t'(cfg_tmo)),
    .cfg_start (start_code_t'(cfg_start)),
    .fault_o   (fault),
    .expire_o  (expire)
  );

  wdog_rst_pulse #(.RST_MS(RST_MS)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_ms),
    .expire   (expire),
    .rst_en   (cfg_rst_en),
    .flag_clr (flag_clr),
    .rst_o    (rst_req_o),
    .cause_o  (cause_flag)
  );

  assign wdo_n = !fault;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic ext_rst_i,
  input logic svc_edge,
  input logic cfg_rst_en,
  input logic flag_clr,
  input logic wdo_n,
  input logic rst_req_o,
  input logic cause_flag
);
  logic held;
  assign held = !enable || ext_rst_i || rst_req_o;

  p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> wdo_n);

  p_ext_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_i |=> wdo_n);

  p_fault_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !held && !svc_edge) |=> !wdo_n);

  p_edge_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && svc_edge) |=> wdo_n);

  p_pulse_with_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> !wdo_n);

  p_short_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |=> wdo_n);

  p_gate_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(cfg_rst_en));

  p_cause_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> cause_flag);

  p_cause_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_flag && !flag_clr && !rst_req_o) |=> cause_flag);
endmodule

bind wdog_supervisor wdog_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .ext_rst_i  (ext_rst_i),
  .svc_edge   (svc_edge),
  .cfg_rst_en (cfg_rst_en),
  .flag_clr   (flag_clr),
  .wdo_n      (wdo_n),
  .rst_req_o  (rst_req_o),
  .cause_flag (cause_flag)
);

// File: tb/wdog_supervisor_tb_top.sv
`timescale 1ns/1ps
module wdog_supervisor_tb_top;
  localparam int RST_MS = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b1;
  logic       enable = 1'b1;
  logic       ext_rst_i = 1'b1;
  logic       svc_i = 1'b0;
  logic [3:0] cfg_tmo = 4'd0;
  logic [2:0] cfg_start = 3'd0;
  logic       cfg_rst_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       wdo_n;
  logic       rst_req_o;
  logic       cause_flag;

  int unsigned cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int unsigned cyc;
    bit          w;
    bit          r;
    bit          c;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t it;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_supervisor #(.RST_MS(RST_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .enable(enable),
    .ext_rst_i(ext_rst_i), .svc_i(svc_i), .cfg_tmo(cfg_tmo),
    .cfg_start(cfg_start), .cfg_rst_en(cfg_rst_en), .flag_clr(flag_clr),
    .wdo_n(wdo_n), .rst_req_o(rst_req_o), .cause_flag(cause_flag)
  );

  function automatic int ref_ms(input int code);
    int t[16] = '{0, 1, 2, 4, 8, 14, 27, 50, 100, 200, 400, 750, 1400, 2700, 5000, 10000};
    return t[code];
  endfunction

  // driver side: queue an expected output triple d cycles from now
  task automatic expect_at(input int d, input bit w, input bit r, input bit c, input string tag);
    exp_t e;
    e.cyc = cyc + d;
    e.w = w; e.r = r; e.c = c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic hold_cfg(input int tmo, input int st, input bit ren);
    ext_rst_i = 1'b1;
    cfg_tmo = 4'(tmo);
    cfg_start = 3'(st);
    cfg_rst_en = ren;
    step(3);
  endtask

  // monitor side: compare in exactly the queued cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      total++;
      if (it.cyc < cyc) begin
        bad++;
        $display("FAIL %s: check for cycle %0d missed, actual cycle=%0d expected cycle=%0d",
                 it.tag, it.cyc, cyc, it.cyc);
      end else if ({wdo_n, rst_req_o, cause_flag} !== {it.w, it.r, it.c}) begin
        bad++;
        $display("FAIL %s at cycle %0d: actual wdo_n/rst/cause=%b%b%b expected=%b%b%b",
                 it.tag, cyc, wdo_n, rst_req_o, cause_flag, it.w, it.r, it.c);
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): actual cycle=%0d expected below 150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int codes[5] = '{2, 3, 5, 8, 6};
    step(3);
    rst_n = 1'b1;
    expect_at(1, 1, 0, 0, "R1");
    drain();

    // R2 / R6 / R7 / R9: period table, no grace window
    foreach (codes[i]) begin
      int len;
      len = ref_ms(codes[i]);
      hold_cfg(codes[i], 0, 1'b0);
      ext_rst_i = 1'b0;
      expect_at(len - 1, 1, 0, 0, (i == 0) ? "R6" : "R2");
      expect_at(len, 0, 0, 0, "R2");
      expect_at(len + 20, 0, 0, 0, "R7");
      drain();
      ext_rst_i = 1'b1;
      expect_at(1, 1, 0, 0, "R9");
      drain();
    end

    // R4: alternating edges keep the 8 ms watchdog quiet, R7: toggle clears the fault
    hold_cfg(4, 0, 1'b0);
    ext_rst_i = 1'b0;
    expect_at(40, 1, 0, 0, "R4");
    step(2);
    for (int k = 0; k < 10; k++) begin
      svc_i = ~svc_i;
      if (k < 9) step(5);
    end
    expect_at(10, 1, 0, 0, "R4");
    expect_at(11, 0, 0, 0, "R4");
    drain();
    step(4);
    svc_i = ~svc_i;
    expect_at(2, 0, 0, 0, "R7");
    expect_at(3, 1, 0, 0, "R7");
    drain();

    // R3: code 0 disables even with reset coupling on
    hold_cfg(0, 0, 1'b1);
    ext_rst_i = 1'b0;
    expect_at(200, 1, 0, 0, "R3");
    drain();

    // R8: enable low holds the count
    ext_rst_i = 1'b1;
    enable = 1'b0;
    cfg_tmo = 4'd1;
    cfg_rst_en = 1'b0;
    step(3);
    ext_rst_i = 1'b0;
    expect_at(50, 1, 0, 0, "R8");
    drain();
    enable = 1'b1;
    expect_at(1, 0, 0, 0, "R8");
    drain();

    // R10 / R11 / R12: reset coupling and cause flag
    hold_cfg(2, 0, 1'b1);
    ext_rst_i = 1'b0;
    expect_at(1, 1, 0, 0, "R10");
    expect_at(2, 0, 1, 1, "R10");
    expect_at(3, 1, 1, 1, "R10");
    expect_at(RST_MS + 1, 1, 1, 1, "R10");
    expect_at(RST_MS + 2, 1, 0, 1, "R10");
    step(RST_MS + 2);
    cfg_rst_en = 1'b0;
    expect_at(2, 0, 0, 1, "R11");
    expect_at(10, 0, 0, 1, "R11");
    drain();
    ext_rst_i = 1'b1;
    expect_at(1, 1, 0, 1, "R12");
    step(2);
    flag_clr = 1'b1;
    expect_at(1, 1, 0, 0, "R12");
    step(1);
    flag_clr = 1'b0;
    drain();

    // R5: 30 s grace window, then first edge switches to 1 ms
    hold_cfg(1, 1, 1'b0);
    ext_rst_i = 1'b0;
    expect_at(29999, 1, 0, 0, "R5");
    expect_at(30000, 0, 0, 0, "R5");
    drain();
    hold_cfg(1, 1, 1'b0);
    ext_rst_i = 1'b0;
    step(100);
    svc_i = ~svc_i;
    expect_at(3, 1, 0, 0, "R5");
    expect_at(4, 0, 0, 0, "R5");
    drain();

    // R13: new code applies only at the next restart
    hold_cfg(3, 0, 1'b0);
    ext_rst_i = 1'b0;
    expect_at(3, 1, 0, 0, "R13");
    expect_at(4, 0, 0, 0, "R13");
    step(1);
    cfg_tmo = 4'd5;
    drain();
    svc_i = ~svc_i;
    expect_at(16, 1, 0, 0, "R13");
    expect_at(17, 0, 0, 0, "R13");
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule